// File: doc/BRIEF.md
# Separate-Port Burst SRAM Model

A synthesizable behavioural model of a synchronous pipelined SRAM with a dedicated read port and a dedicated write port. It stands in for the memory while a controller is exercised. Each access moves four words. A read select starts a four-word read burst that returns after a fixed latency. A write select starts a four-word write burst with per-byte lane enables. Read data and write data never share a bus, so no turnaround cycle exists between them.

The double-data-rate interface is modelled with one clock that runs at twice the rate of the notional input clock K. Each cycle of `clk` is one half-period of K. The output `k_high` is 1 during the half that follows a K rising edge. Selects are sampled at edges where `k_high` is 0, because those edges are K rising edges. Storage is four banks, one for each beat position. An address picks one word from every bank.

The read side has a burst machine with states RD_IDLE, RD_B0, RD_B1, RD_B2 and RD_B3:
- RD_IDLE goes to RD_B0 when a request that has passed the two-K-cycle latency pipeline is loaded at a K rising edge.
- RD_B0 goes to RD_B1, RD_B1 to RD_B2, and RD_B2 to RD_B3, unconditionally.
- RD_B3 goes to RD_B0 if another request is loaded at that edge, and otherwise to RD_IDLE.

The write side has states WR_IDLE, WR_W0, WR_W1, WR_W2 and WR_W3:
- WR_IDLE goes to WR_W0 when a write select is accepted.
- WR_W0 commits word 0 and takes the write address, then goes to WR_W1.
- WR_W1 and WR_W2 commit words 1 and 2 and step on.
- WR_W3 commits word 3, then goes to WR_W0 on a new accepted select and otherwise to WR_IDLE.

Top module: `bsram_sep`

## Requirements
- R1: While `rst_n` is low, `k_high`, `rd_valid` and `rd_q` are 0. The first edge after release is a K rising edge. From then on `k_high` alternates every cycle.
- R2: A read is accepted at an edge where `k_high` is 0 and `rd_n` is 0. The read address is taken from `addr` at that edge.
- R3: After an accepted read, `rd_valid` stays 0 for the next three edges. It goes to 1 after the fourth edge, which is the second K rise following the request, and it does so in a half where `k_high` is 1.
- R4: A burst holds `rd_valid` at 1 for exactly four cycles. `rd_q` shows bank 0, 1, 2, then 3 of the read address, in that order. `rd_q` is 0 whenever `rd_valid` is 0.
- R5: A low `rd_n` at an edge where `k_high` is 1 starts no read.
- R6: A read select at the K rise right after an accepted read is ignored. A select at the K rise after that is accepted, and its burst follows the first with no gap, giving eight valid cycles.
- R7: A write is accepted at an edge where `k_high` is 0 and `wr_n` is 0, provided the write side is idle or is taking its last word. At the next edge, `addr` gives the write address and `wr_data` gives word 0. Words 1, 2 and 3 are taken at the three edges that follow. Writes may run back to back.
- R8: At each write word, byte lane i is `wr_data[9*i+8:9*i]`. That lane is stored only when `bw_n[i]` is 0. Otherwise the stored lane keeps its old value.
- R9: A write select at the K rise in the middle of a write burst is ignored.
- R10: A read and a write may be accepted at the same edge. A read of the address being written returns the new words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; one cycle per K half-period |
| rst_n | input | 1 | Synchronous active-low reset |
| k_high | output | 1 | 1 in the half-period that follows a K rising edge |
| rd_n | input | 1 | Active-low read select |
| wr_n | input | 1 | Active-low write select |
| addr | input | ADDR_W | Shared address: the read address at a K rise, the write address one half later |
| wr_data | input | BYTES*BYTE_W | Write data, one word per cycle |
| bw_n | input | BYTES | Active-low byte lane write enables |
| rd_valid | output | 1 | Marks each of the four read beats |
| rd_q | output | BYTES*BYTE_W | Read data |

## Verification
On every cycle the assertions check the timing of the read stream:
- a burst only begins in a K-high half, exactly five samples after a select at a K rise;
- a burst ends only after four valid beats;
- a burst ends on a K boundary.

The bench scenarios are the only way to show the data content and the word order of the bursts. They also cover:
- byte-lane masking;
- dropping of selects at the wrong phase or inside the busy window;
- back-to-back chaining of reads and of writes;
- a write observed by a read accepted at the same edge.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
    localparam int BEATS      = 4;
    localparam int BEAT_IDX_W = $clog2(BEATS);

    typedef enum logic [2:0] {
        RD_IDLE, RD_B0, RD_B1, RD_B2, RD_B3
    } rd_state_e;

    typedef enum logic [2:0] {
        WR_IDLE, WR_W0, WR_W1, WR_W2, WR_W3
    } wr_state_e;
endpackage

// File: rtl/bsram_bank.sv
module bsram_bank #(
    parameter int ADDR_W = 4,
    parameter int BYTE_W = 9,
    parameter int BYTES  = 2
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic [BYTES-1:0]          lane_en,
    input  logic [ADDR_W-1:0]         waddr,
    input  logic [BYTES*BYTE_W-1:0]   wdata,
    input  logic [ADDR_W-1:0]         raddr,
    output logic [BYTES*BYTE_W-1:0]   rdata
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = BYTES * BYTE_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int b = 0; b < BYTES; b++) begin
                if (lane_en[b]) begin
                    mem[waddr][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
                end
            end
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/bsram_rd_ctrl.sv
module bsram_rd_ctrl
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  k_rise,
    input  logic                  rd_n,
    input  logic [ADDR_W-1:0]     addr,
    output logic                  beat_valid,
    output logic [BEAT_IDX_W-1:0] beat_idx,
    output logic [ADDR_W-1:0]     raddr
);
    rd_state_e         st, st_nx;
    logic              s1_v, s2_v;
    logic [ADDR_W-1:0] s1_a, s2_a, b_a;
    logic              accept, load;

    // A request is accepted only at a K rise and not right after another one.
    assign accept = k_rise && !rd_n && !s1_v;
    assign load   = k_rise && s2_v && (st == RD_IDLE || st == RD_B3);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= RD_IDLE;
            s1_v <= 1'b0;
            s2_v <= 1'b0;
            s1_a <= '0;
            s2_a <= '0;
            b_a  <= '0;
        end else begin
            st <= st_nx;
            if (k_rise) begin
                s1_v <= accept;
                s1_a <= addr;
                s2_v <= s1_v;
                s2_a <= s1_a;
            end
            if (load) begin
                b_a <= s2_a;
            end
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            RD_IDLE: st_nx = load ? RD_B0 : RD_IDLE;
            RD_B0:   st_nx = RD_B1;
            RD_B1:   st_nx = RD_B2;
            RD_B2:   st_nx = RD_B3;
            RD_B3:   st_nx = load ? RD_B0 : RD_IDLE;
            default: st_nx = RD_IDLE;
        endcase
    end

    always_comb begin
        beat_valid = 1'b1;
        beat_idx   = '0;
        unique case (st)
            RD_B0:   beat_idx = BEAT_IDX_W'(0);
            RD_B1:   beat_idx = BEAT_IDX_W'(1);
            RD_B2:   beat_idx = BEAT_IDX_W'(2);
            RD_B3:   beat_idx = BEAT_IDX_W'(3);
            default: beat_valid = 1'b0;
        endcase
    end

    assign raddr = b_a;
endmodule

// File: rtl/bsram_wr_ctrl.sv
module bsram_wr_ctrl
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int BYTES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              k_rise,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTES-1:0]  bw_n,
    output logic [BEATS-1:0]  bank_we,
    output logic [ADDR_W-1:0] waddr,
    output logic [BYTES-1:0]  lane_en
);
    wr_state_e         st, st_nx;
    logic [ADDR_W-1:0] wa_q;
    logic              accept;

    assign accept = k_rise && !wr_n && (st == WR_IDLE || st == WR_W3);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= WR_IDLE;
            wa_q <= '0;
        end else begin
            st <= st_nx;
            if (st == WR_W0) begin
                wa_q <= addr;
            end
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            WR_IDLE: st_nx = accept ? WR_W0 : WR_IDLE;
            WR_W0:   st_nx = WR_W1;
            WR_W1:   st_nx = WR_W2;
            WR_W2:   st_nx = WR_W3;
            WR_W3:   st_nx = accept ? WR_W0 : WR_IDLE;
            default: st_nx = WR_IDLE;
        endcase
    end

    always_comb begin
        bank_we = '0;
        unique case (st)
            WR_W0:   bank_we[0] = 1'b1;
            WR_W1:   bank_we[1] = 1'b1;
            WR_W2:   bank_we[2] = 1'b1;
            WR_W3:   bank_we[3] = 1'b1;
            default: bank_we = '0;
        endcase
        // The write address arrives on the half after the select.
        waddr   = (st == WR_W0) ? addr : wa_q;
        lane_en = ~bw_n;
    end
endmodule

// File: rtl/bsram_sep.sv
module bsram_sep
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int BYTE_W = 9,
    parameter int BYTES  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    output logic                     k_high,
    input  logic                     rd_n,
    input  logic                     wr_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [BYTES*BYTE_W-1:0]  wr_data,
    input  logic [BYTES-1:0]         bw_n,
    output logic                     rd_valid,
    output logic [BYTES*BYTE_W-1:0]  rd_q
);
    localparam int DATA_W = BYTES * BYTE_W;

    logic                  kph;
    logic                  k_rise;
    logic                  beat_valid;
    logic [BEAT_IDX_W-1:0] beat_idx;
    logic [ADDR_W-1:0]     raddr, waddr;
    logic [BEATS-1:0]      bank_we;
    logic [BYTES-1:0]      lane_en;
    logic [DATA_W-1:0]     bank_q [BEATS];

    always_ff @(posedge clk) begin
        if (!rst_n) kph <= 1'b0;
        else        kph <= ~kph;
    end
    assign k_rise = ~kph;
    assign k_high = kph;

    bsram_rd_ctrl #(.ADDR_W(ADDR_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .k_rise(k_rise), .rd_n(rd_n), .addr(addr),
        .beat_valid(beat_valid), .beat_idx(beat_idx), .raddr(raddr)
    );

    bsram_wr_ctrl #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_wr (
        .clk(clk), .rst_n(rst_n), .k_rise(k_rise), .wr_n(wr_n), .addr(addr),
        .bw_n(bw_n), .bank_we(bank_we), .waddr(waddr), .lane_en(lane_en)
    );

    for (genvar g = 0; g < BEATS; g++) begin : g_bank
        bsram_bank #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .BYTES(BYTES)) u_bank (
            .clk(clk), .we(bank_we[g]), .lane_en(lane_en), .waddr(waddr),
            .wdata(wr_data), .raddr(raddr), .rdata(bank_q[g])
        );
    end

    always_comb begin
        rd_valid = beat_valid;
        rd_q     = beat_valid ? bank_q[beat_idx] : '0;
    end
endmodule

// File: rtl/bsram_sep_chk.sv
module bsram_sep_chk (
    input logic clk,
    input logic rst_n,
    input logic k_high,
    input logic rd_n,
    input logic rd_valid
);
    // R3: a burst begins in a K-high half
    p_start_khigh_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> k_high);

    // R3: a burst begins five samples after a select taken at a K rise
    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $past(!rd_n && !k_high, 5));

    // R4: a burst lasts at least four valid beats
    p_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_valid) |-> $past(rd_valid, 4));

    // R4: a burst ends on a K boundary
    p_end_khigh_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_valid) |-> k_high);
endmodule

bind bsram_sep bsram_sep_chk u_chk (
    .clk(clk), .rst_n(rst_n), .k_high(k_high), .rd_n(rd_n), .rd_valid(rd_valid)
);

// File: tb/tb_bsram_sep.sv
`timescale 1ns/1ps
module tb_bsram_sep;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        k_high;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [3:0]  addr = '0;
    logic [17:0] wr_data = '0;
    logic [1:0]  bw_n = 2'b11;
    logic        rd_valid;
    logic [17:0] rd_q;

    int n_chk = 0;
    int n_fail = 0;
    logic [17:0] shadow [4][16];

    always #2.5 clk = ~clk;

    bsram_sep dut (
        .clk(clk), .rst_n(rst_n), .k_high(k_high), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wr_data(wr_data), .bw_n(bw_n), .rd_valid(rd_valid), .rd_q(rd_q)
    );

    // Address and seed for each table entry
    localparam logic [21:0] VEC [6] = '{
        {4'h1, 18'h0A5C3}, {4'h2, 18'h3F00F}, {4'h5, 18'h12345},
        {4'h7, 18'h2AAAA}, {4'h9, 18'h15555}, {4'hE, 18'h3C3C3}
    };

    function automatic logic [71:0] words_of(input logic [17:0] seed);
        logic [71:0] w;
        for (int i = 0; i < 4; i++) w[i*18 +: 18] = seed ^ (18'(i) * 18'h05A5B);
        return w;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic align();
        @(negedge clk);
        while (k_high) @(negedge clk);
    endtask

    task automatic shadow_put(input int b, input logic [3:0] a,
                              input logic [17:0] w, input logic [1:0] bwn);
        for (int l = 0; l < 2; l++)
            if (!bwn[l]) shadow[b][a][l*9 +: 9] = w[l*9 +: 9];
    endtask

    task automatic do_write(input logic [3:0] a, input logic [71:0] w, input logic [7:0] bwn);
        align();
        wr_n = 1'b0; addr = 4'h0;
        for (int b = 0; b < 4; b++) begin
            @(negedge clk);
            wr_n = 1'b1; addr = a;
            wr_data = w[b*18 +: 18]; bw_n = bwn[b*2 +: 2];
            shadow_put(b, a, w[b*18 +: 18], bwn[b*2 +: 2]);
        end
        @(negedge clk);
        bw_n = 2'b11; wr_data = '0;
    endtask

    task automatic do_read(input logic [3:0] a, input string req);
        align();
        rd_n = 1'b0; addr = a;
        @(negedge clk);
        rd_n = 1'b1;
        repeat (3) @(negedge clk);
        check({"R3 no early data ", req}, 32'(rd_valid), 32'd0);
        for (int b = 0; b < 4; b++) begin
            @(negedge clk);
            check({"R4 beat valid ", req}, 32'(rd_valid), 32'd1);
            check({"R4 beat data ", req}, 32'(rd_q), 32'(shadow[b][a]));
        end
        @(negedge clk);
        check({"R4 burst end ", req}, 32'(rd_valid), 32'd0);
        check({"R4 idle bus ", req}, 32'(rd_q), 32'd0);
    endtask

    initial begin
        int seen;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 k_high in reset", 32'(k_high), 32'd0);
        check("R1 rd_valid in reset", 32'(rd_valid), 32'd0);
        check("R1 rd_q in reset", 32'(rd_q), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 first edge is K rise", 32'(k_high), 32'd1);
        @(negedge clk);
        check("R1 phase alternates", 32'(k_high), 32'd0);

        // Table walk: write every entry, then read each back (R2 R4 R7)
        foreach (VEC[i]) do_write(VEC[i][21:18], words_of(VEC[i][17:0]), 8'h00);
        foreach (VEC[i]) do_read(VEC[i][21:18], "R2 table");

        // R8: byte-lane masking per word
        do_write(4'h5, {18'h3FFFF, 18'h00000, 18'h2D2D2, 18'h1B1B1},
                 {2'b00, 2'b11, 2'b10, 2'b01});
        do_read(4'h5, "R8 lanes");

        // R5: select at a complement edge is ignored
        align();
        @(negedge clk);
        rd_n = 1'b0; addr = 4'h1;
        @(negedge clk);
        rd_n = 1'b1;
        seen = 0;
        for (int t = 0; t < 10; t++) begin
            @(negedge clk);
            if (rd_valid) seen = 1;
        end
        check("R5 no burst", 32'(seen), 32'd0);

        // R6: select at the next K rise is dropped
        align();
        rd_n = 1'b0; addr = 4'h1;
        for (int t = 0; t < 12; t++) begin
            @(negedge clk);
            if (t >= 4 && t < 8) begin
                check("R6 first burst valid", 32'(rd_valid), 32'd1);
                check("R6 first burst data", 32'(rd_q), 32'(shadow[t-4][4'h1]));
            end else if (t >= 8) begin
                check("R6 dropped request", 32'(rd_valid), 32'd0);
            end
            if (t == 0) rd_n = 1'b1;
            if (t == 1) begin rd_n = 1'b0; addr = 4'h2; end
            if (t == 2) rd_n = 1'b1;
        end

        // R6: select two K rises later chains with no gap
        align();
        rd_n = 1'b0; addr = 4'h1;
        for (int t = 0; t < 13; t++) begin
            @(negedge clk);
            if (t >= 4 && t < 8) begin
                check("R6 chain A valid", 32'(rd_valid), 32'd1);
                check("R6 chain A data", 32'(rd_q), 32'(shadow[t-4][4'h1]));
            end else if (t >= 8 && t < 12) begin
                check("R6 chain B valid", 32'(rd_valid), 32'd1);
                check("R6 chain B data", 32'(rd_q), 32'(shadow[t-8][4'h7]));
            end else if (t == 12) begin
                check("R6 chain end", 32'(rd_valid), 32'd0);
            end
            if (t == 0) rd_n = 1'b1;
            if (t == 3) begin rd_n = 1'b0; addr = 4'h7; end
            if (t == 4) rd_n = 1'b1;
        end

        // R9: write select mid-burst is ignored; address 9 must stay intact
        align();
        wr_n = 1'b0; addr = 4'h3;
        for (int t = 0; t < 9; t++) begin
            @(negedge clk);
            wr_n = 1'b1;
            if (t < 4) begin
                addr = (t == 0) ? 4'h3 : 4'h9;
                wr_data = 18'h01010 + 18'(t); bw_n = 2'b00;
                shadow_put(t, 4'h3, wr_data, 2'b00);
                if (t == 1) wr_n = 1'b0;
            end else begin
                addr = 4'h9; wr_data = 18'h3ABCD; bw_n = (t == 8) ? 2'b11 : 2'b00;
            end
        end
        do_read(4'h9, "R9 untouched");
        do_read(4'h3, "R9 first write");

        // R7: back-to-back writes
        align();
        wr_n = 1'b0;
        for (int t = 0; t < 9; t++) begin
            @(negedge clk);
            wr_n = 1'b1; bw_n = 2'b00;
            if (t < 4) begin
                addr = 4'hA; wr_data = 18'h20000 ^ 18'(t * 7);
                shadow_put(t, 4'hA, wr_data, 2'b00);
                if (t == 3) wr_n = 1'b0;
            end else if (t < 8) begin
                addr = 4'hB; wr_data = 18'h0F000 ^ 18'(t * 5);
                shadow_put(t - 4, 4'hB, wr_data, 2'b00);
            end else begin
                bw_n = 2'b11;
            end
        end
        do_read(4'hA, "R7 chained first");
        do_read(4'hB, "R7 chained second");

        // R10: read and write of one address accepted at the same edge
        align();
        rd_n = 1'b0; wr_n = 1'b0; addr = 4'hE;
        for (int t = 0; t < 9; t++) begin
            @(negedge clk);
            if (t >= 4 && t < 8) begin
                check("R10 valid", 32'(rd_valid), 32'd1);
                check("R10 new data", 32'(rd_q), 32'(18'h11100 + 18'(t - 4)));
            end
            rd_n = 1'b1; wr_n = 1'b1; addr = 4'hE;
            if (t < 4) begin
                wr_data = 18'h11100 + 18'(t); bw_n = 2'b00;
                shadow_put(t, 4'hE, wr_data, 2'b00);
            end else begin
                bw_n = 2'b11;
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog (all) actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule